// File: doc/BRIEF.md
# Pipelined Natural Exponential Unit

This block evaluates e^x in fixed point for an unsigned fractional operand x that lies below ln 2. It works by restoring shift-and-add: every stage tries to remove a wired-in constant ln(1+2^-k) from a running residual. When the constant fits, the stage scales a running product by (1+2^-k) using only a shift and an add. After the last stage, one explicit Euler step replaces the remaining iterations. That step multiplies the product by (1+residual), using a truncated multiplier that produces only the bits lining up with the product.

The result is the fraction of a significand in [1, 2) with its leading one implied. This is the form a floating-point or logarithmic datapath expects after it has split an exponent off an operand. The iterations are fully unrolled and each has its own register, so one operand can enter on every clock cycle. A valid flag travels alongside the data. The caller must keep operands inside the domain; range reduction happens elsewhere.

Top module: `exp_sa_unit`

## Requirements
- R1: A result appears on `valid_o` exactly N_ITER+1 cycles after its operand was presented with `valid_i`. Operands can be presented on consecutive cycles with no bubble, and results come out in the same order.
- R2: While `rst_ni` is low, and afterwards until the first operand has passed through, `valid_o` stays low.
- R3: `sig_o` carries OUT_FW fraction bits. Its value s represents 1 + s/2^OUT_FW. For `x_i` read as x/2^IN_FW, s is within 1 unit of (e^x − 1)·2^OUT_FW.
- R4: An operand of zero gives a result of exactly zero.
- R5: Results never decrease as the operand increases by one code.
- R6: In every stage, adding the shifted product never carries into the implied integer one.
- R7: The residual leaving stage k is below 2^-k. This lets each stage's residual datapath be one bit narrower than the previous stage's.
- R8: The truncated correction term of the Euler step never exceeds the residual it is derived from.
- R9: Operands presented with `valid_i` are below round(ln 2 · 2^IN_FW), which is 45426 for IN_FW = 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand present this cycle |
| x_i | input | IN_FW | Operand, unsigned fraction x/2^IN_FW |
| valid_o | output | 1 | Result present this cycle |
| sig_o | output | OUT_FW | Significand fraction; the leading one is implied |

## Verification
The case that matters is a new operand being captured in the same cycle that an older result leaves the last stage. This happens on every cycle once the pipeline is full. The bench provokes it with an unbroken sweep over every legal operand code, and again with a stream that has irregular gaps. A scoreboard stamps each operand with the cycle in which its result is due. It then judges each emerging result on three points: arrival in exactly that cycle, a value within one unit of a real-valued exponential, and no decrease against the result for the preceding code.

// File: rtl/exp_sa_pkg.sv
package exp_sa_pkg;

  // round(ln(1 + 2^-k) * 2^fw), computed at elaboration
  function automatic logic [31:0] ln_term(input int k, input int fw);
    real v;
    v = $ln(1.0 + 2.0 ** (-k)) * (2.0 ** fw);
    return 32'($rtoi(v + 0.5));
  endfunction

endpackage

// File: rtl/exp_iter_stage.sv
module exp_iter_stage
  import exp_sa_pkg::*;
#(
  parameter int K  = 1,
  parameter int WF = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [WF-1:0] e_i,
  input  logic [WF-1:0] l_i,
  output logic          vld_o,
  output logic [WF-1:0] e_o,
  output logic [WF-1:0] l_o
);
  localparam int LW_I = WF - K + 1;
  localparam int LW_O = WF - K;
  localparam logic [31:0]     C_FULL = ln_term(K, WF);
  localparam logic [LW_I-1:0] C_K    = C_FULL[LW_I-1:0];

  logic [LW_I-1:0] l_in, l_next;
  logic            take;
  logic [WF:0]     e_shift, e_sum;
  logic [LW_O-1:0] l_q;

  assign l_in    = l_i[LW_I-1:0];
  assign take    = (l_in >= C_K);
  assign l_next  = take ? (l_in - C_K) : l_in;
  assign e_shift = {1'b1, e_i} >> K;
  assign e_sum   = {1'b0, e_i} + e_shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      e_o   <= '0;
      l_q   <= '0;
    end else begin
      vld_o <= vld_i;
      e_o   <= take ? e_sum[WF-1:0] : e_i;
      l_q   <= l_next[LW_O-1:0];
    end
  end

  assign l_o = WF'(l_q);

  // R6
  e_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && take) |-> !e_sum[WF]);

  // R7
  residual_fits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |-> !l_next[LW_I-1]);

  generate
    if (K > 1) begin : g_hi
      // R7
      residual_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_i |-> (l_i[WF-1:LW_I] == '0));
    end
  endgenerate

endmodule

// File: rtl/exp_euler_stage.sv
module exp_euler_stage #(
  parameter int WF       = 24,
  parameter int N_ITER   = 10,
  parameter int OUT_FW   = 16,
  parameter int MUL_DROP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [WF-1:0]     e_i,
  input  logic [WF-1:0]     l_i,
  output logic              vld_o,
  output logic [OUT_FW-1:0] sig_o
);
  localparam int LW = WF - N_ITER;
  localparam int AW = WF - MUL_DROP;
  localparam int PW = AW + LW;
  localparam int RB = WF - OUT_FW;
  localparam logic [WF+1:0] HALF = (WF+2)'(1) << (RB - 1);

  logic [LW-1:0]     l_low, corr;
  logic [AW-1:0]     e_top;
  logic [PW-1:0]     prod;
  logic [WF+1:0]     sum, rnd;
  logic [RB-1:0]     rnd_unused;
  logic              sat;
  logic [OUT_FW-1:0] sig_d;

  assign l_low = l_i[LW-1:0];
  assign e_top = e_i[WF-1:MUL_DROP];
  // truncated operands; carries of the dropped partial products are lost
  assign prod  = PW'(e_top) * PW'(l_low);
  assign corr  = prod[PW-1:AW];
  assign sum   = (WF+2)'(e_i) + (WF+2)'(l_low) + (WF+2)'(corr);
  assign rnd   = sum + HALF;
  assign rnd_unused = rnd[RB-1:0];
  assign sat   = (rnd[WF+1:WF] != 2'b00);
  assign sig_d = sat ? '1 : rnd[WF-1:RB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      sig_o <= '0;
    end else begin
      vld_o <= vld_i;
      sig_o <= sig_d;
    end
  end

  // R8
  corr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |-> (corr <= l_low));

  // R7
  final_residual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |-> (l_i[WF-1:LW] == '0));

endmodule

// File: rtl/exp_sa_unit.sv
module exp_sa_unit
  import exp_sa_pkg::*;
#(
  parameter int IN_FW    = 16,
  parameter int OUT_FW   = 16,
  parameter int GUARD    = 8,
  parameter int N_ITER   = 10,
  parameter int MUL_DROP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IN_FW-1:0]  x_i,
  output logic              valid_o,
  output logic [OUT_FW-1:0] sig_o
);
  localparam int WF = OUT_FW + GUARD;
  localparam logic [31:0]      LN2_FULL = ln_term(0, IN_FW);
  localparam logic [IN_FW-1:0] LN2_CODE = LN2_FULL[IN_FW-1:0];

  logic [WF-1:0] e_pipe [N_ITER+1];
  logic [WF-1:0] l_pipe [N_ITER+1];
  logic          v_pipe [N_ITER+1];

  assign e_pipe[0] = '0;
  assign l_pipe[0] = WF'(x_i) << (WF - IN_FW);
  assign v_pipe[0] = valid_i;

  generate
    for (genvar k = 1; k <= N_ITER; k++) begin : g_stage
      exp_iter_stage #(.K(k), .WF(WF)) u_stage (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .vld_i (v_pipe[k-1]),
        .e_i   (e_pipe[k-1]),
        .l_i   (l_pipe[k-1]),
        .vld_o (v_pipe[k]),
        .e_o   (e_pipe[k]),
        .l_o   (l_pipe[k])
      );
    end
  endgenerate

  exp_euler_stage #(
    .WF(WF), .N_ITER(N_ITER), .OUT_FW(OUT_FW), .MUL_DROP(MUL_DROP)
  ) u_euler (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (v_pipe[N_ITER]),
    .e_i   (e_pipe[N_ITER]),
    .l_i   (l_pipe[N_ITER]),
    .vld_o (valid_o),
    .sig_o (sig_o)
  );

  // R9
  in_domain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (x_i < LN2_CODE));

endmodule

// File: tb/exp_sa_unit_tb_top.sv
`timescale 1ns/1ps
module exp_sa_unit_tb_top;
  localparam int IN_FW  = 16;
  localparam int OUT_FW = 16;
  localparam int N_ITER = 10;
  localparam int LAT    = N_ITER + 1;
  localparam int X_LIM  = 45426;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid_i = 1'b0;
  logic [IN_FW-1:0]  x_i = '0;
  logic              valid_o;
  logic [OUT_FW-1:0] sig_o;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int q_x[$];
  int q_t[$];
  int last_x = -10;
  int last_out = 0;

  exp_sa_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .x_i(x_i),
    .valid_o(valid_o), .sig_o(sig_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic drive(input int x);
    @(negedge clk);
    valid_i = 1'b1;
    x_i = IN_FW'(x);
    q_x.push_back(x);
    q_t.push_back(cyc + LAT);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o) begin
        if (q_x.size() == 0) begin
          check(1'b0, "R1 unexpected result", 1, 0);
        end else begin
          int x, t, expv;
          real ideal, d;
          x = q_x.pop_front();
          t = q_t.pop_front();
          check(cyc == t, "R1 latency", cyc, t);
          ideal = ($exp(real'(x) / 65536.0) - 1.0) * 65536.0;
          expv  = $rtoi(ideal + 0.5);
          d = real'(sig_o) - ideal;
          // R3 (sweep also drives the internal R6 R7 R8 properties)
          check(d <= 1.0 && d >= -1.0, "R3 accuracy", int'(sig_o), expv);
          if (x == 0) check(sig_o == '0, "R4 zero operand", int'(sig_o), 0);
          if (x == last_x + 1)
            check(int'(sig_o) >= last_out, "R5 monotonic", int'(sig_o), last_out);
          last_x = x;
          last_out = int'(sig_o);
        end
      end else if (q_t.size() != 0 && q_t[0] <= cyc) begin
        check(1'b0, "R1 missing result", 0, q_t[0]);
        void'(q_x.pop_front());
        void'(q_t.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R2: reset state
    repeat (3) begin
      @(negedge clk);
      check(valid_o == 1'b0, "R2 valid during reset", int'(valid_o), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(valid_o == 1'b0, "R2 valid after reset", int'(valid_o), 0);
    end

    // R4: single zero operand, then drain
    drive(0);
    idle(LAT + 2);

    // R1 R3 R5: unbroken sweep over every legal code (R9 bound respected)
    for (int x = 0; x < X_LIM; x++) drive(x);
    idle(LAT + 2);

    // R1 R3: gapped, scattered stream
    for (int i = 0; i < 3000; i++) begin
      drive((i * 7919) % X_LIM);
      if (i % 3 == 0) idle(1 + (i % 2));
    end
    idle(LAT + 2);

    // R3 R5: top end of domain, ascending
    for (int x = X_LIM - 40; x < X_LIM; x++) drive(x);
    idle(LAT + 3);

    check(q_x.size() == 0, "R1 drained", q_x.size(), 0);
    finish_run();
  end

endmodule